// File: doc/BRIEF.md
# Stereo PWM Output Modulator

This block turns one signed multi-bit sample per audio channel into a pair of pulse-width-modulated outputs (a positive leg and a negative leg) that drive the gate drivers of an H-bridge. Both stereo channels share one free-running carrier counter, so all four outputs switch on a common grid. Every pulse starts at the beginning of a carrier period. Its length is the period's midpoint, moved by the sample scaled with a selectable modulation index.

Two 2-bit codes set the operating point. The index code limits the duty swing to 50%, 62.5%, 75% or 87.5% of full scale. The mapping code picks one of two output styles. In complementary two-level mode (AD) the negative leg mirrors the positive leg. In three-level mode (BD) the two legs are modulated by opposite-signed copies of the sample. One mapping code also halves the carrier period, which doubles the switching rate. A mute input replaces the output with an idle waveform that has no differential content.

Samples, codes and mute are all taken in only on the last count of a carrier period. A change therefore never cuts a pulse short in the middle of a period.

Top module: `stereo_pwm_mod`

## Requirements
- R1: While `rst` is high, all four outputs are low. From reset release until the first period boundary, each channel's two legs are identical (idle).
- R2: The carrier period is 2^CNT_W clocks for mapping codes 00, 10 and 11, and 2^(CNT_W-1) clocks for mapping code 01. Each positive leg rises exactly once per period, at its start.
- R3: For sample x (two's complement, SAMPLE_W bits), modulation weight k and period P, the positive leg is high for P/2 + floor(k·x·P / 2^(SAMPLE_W+3)) clocks. Those clocks begin at the period start.
- R4: Index code 00, 01, 10, 11 selects k = 4, 5, 6, 7 (eighths of full swing).
- R5: In AD mode (mapping code 00, 01 or 11, not muted), the negative leg is the exact inverse of the positive leg in every clock.
- R6: In BD mode (mapping code 10, not muted), the negative leg follows the R3 rule with -x in place of x. Both legs rise at the period start, so a zero sample gives two identical 50% waveforms.
- R7: The mapping code is decoded as: 00 selects AD at the full period, 01 selects AD at the half period, 10 selects BD at the full period, 11 selects AD at the full period.
- R8: With `mute` high, both legs of both channels are high for exactly P/2 clocks from the period start and identical in every clock, whatever the sample and the mapping style. The period still follows the mapping code.
- R9: Samples, codes and mute take effect only from the next carrier period. The period in progress keeps its pulse widths unchanged.
- R10: The left and right channels are computed independently from their own samples.
- R11: For every sample and index, the high time of a leg lies strictly between 0 and P clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_l | input | SAMPLE_W | Left channel sample, signed |
| sample_r | input | SAMPLE_W | Right channel sample, signed |
| idx_code | input | 2 | Modulation index code |
| map_code | input | 2 | Output mapping and carrier rate code |
| mute | input | 1 | Active-high mute |
| pwm_l_p | output | 1 | Left positive leg |
| pwm_l_n | output | 1 | Left negative leg |
| pwm_r_p | output | 1 | Right positive leg |
| pwm_r_n | output | 1 | Right negative leg |

## Verification
The outputs are registered one clock behind the carrier count. A new input is taken in at the final count of the current period and shows on the outputs from the first clock of the following period. A change therefore reaches the pins between one clock and one full period plus one clock after it is driven. Each check waits two clocks after driving inputs, then locates the next rising edge of the left positive leg. From that edge it counts high clocks on all four legs over one whole period, up to the following rising edge, so a partial period is never judged. The boundary test counts the period in which the inputs change and expects the old widths there, and the new widths only in the period after.

// File: rtl/pwm_mod_pkg.sv
package pwm_mod_pkg;

  typedef struct packed {
    logic three_level;
    logic fast;
  } map_cfg_t;

  function automatic map_cfg_t decode_map(input logic [1:0] code);
    map_cfg_t c;
    c.three_level = (code == 2'b10);
    c.fast        = (code == 2'b01);
    return c;
  endfunction

  function automatic logic [2:0] index_eighths(input logic [1:0] code);
    return 3'd4 + {1'b0, code};
  endfunction

endpackage

// File: rtl/pwm_carrier.sv
module pwm_carrier #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST_FULL = '1;
  localparam logic [CNT_W-1:0] LAST_FAST = {1'b0, {(CNT_W-1){1'b1}}};

  assign wrap = (cnt == (fast ? LAST_FAST : LAST_FULL));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    fast |-> !cnt[CNT_W-1]);

endmodule

// File: rtl/pwm_level_calc.sv
module pwm_level_calc #(
  parameter int SAMPLE_W = 8,
  parameter int CNT_W    = 6
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [2:0]                 eighths,
  input  logic                       negate,
  input  logic                       fast,
  output logic [CNT_W-1:0]           level
);
  localparam int XW         = SAMPLE_W + 1;
  localparam int PW         = XW + 4;
  localparam int SHIFT_FULL = SAMPLE_W + 3 - CNT_W;
  localparam logic signed [PW-1:0] CENTRE_FULL = PW'(2 ** (CNT_W - 1));
  localparam logic signed [PW-1:0] CENTRE_FAST = PW'(2 ** (CNT_W - 2));
  localparam logic signed [PW-1:0] SPAN_FULL   = PW'(2 ** CNT_W);
  localparam logic signed [PW-1:0] SPAN_FAST   = PW'(2 ** (CNT_W - 1));

  logic signed [XW-1:0] x_ext;
  logic signed [XW-1:0] x_sel;
  logic signed [3:0]    weight;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [PW-1:0] total;

  always_comb begin
    x_ext  = {sample[SAMPLE_W-1], sample};
    x_sel  = negate ? -x_ext : x_ext;
    weight = $signed({1'b0, eighths});
    prod   = PW'(weight) * PW'(x_sel);
    scaled = fast ? (prod >>> (SHIFT_FULL + 1)) : (prod >>> SHIFT_FULL);
    total  = (fast ? CENTRE_FAST : CENTRE_FULL) + scaled;
    level  = total[CNT_W-1:0];
  end

  // R11
  always_comb begin
    duty_clear_chk: assert (total > 0 && total < (fast ? SPAN_FAST : SPAN_FULL));
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int SAMPLE_W = 8,
  parameter int CNT_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       load,
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [2:0]                 eighths,
  input  logic                       fast_next,
  input  logic                       mute_next,
  input  logic                       three_act,
  input  logic                       mute_act,
  input  logic [CNT_W-1:0]           cnt,
  output logic                       pwm_p,
  output logic                       pwm_n
);
  localparam logic [CNT_W-1:0] MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] eff;
  logic [CNT_W-1:0] lvl_d [2];
  logic [CNT_W-1:0] lvl_q [2];

  assign eff = mute_next ? '0 : sample;

  for (genvar s = 0; s < 2; s++) begin : g_leg
    pwm_level_calc #(
      .SAMPLE_W(SAMPLE_W),
      .CNT_W   (CNT_W)
    ) u_lvl (
      .sample (eff),
      .eighths(eighths),
      .negate (1'(s)),
      .fast   (fast_next),
      .level  (lvl_d[s])
    );

    always_ff @(posedge clk) begin
      if (rst)       lvl_q[s] <= MID;
      else if (load) lvl_q[s] <= lvl_d[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_p <= 1'b0;
      pwm_n <= 1'b0;
    end else begin
      pwm_p <= (cnt < lvl_q[0]);
      pwm_n <= (three_act || mute_act) ? (cnt < lvl_q[1]) : !(cnt < lvl_q[0]);
    end
  end

  // R5
  ad_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    (!three_act && !mute_act) |=> (pwm_n != pwm_p));

  // R8
  mute_phase_chk: assert property (@(posedge clk) disable iff (rst)
    mute_act |=> (pwm_n == pwm_p));

  // R6
  bd_start_chk: assert property (@(posedge clk) disable iff (rst)
    (three_act && !mute_act && cnt == '0) |=> (pwm_p && pwm_n));

endmodule

// File: rtl/stereo_pwm_mod.sv
module stereo_pwm_mod
  import pwm_mod_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int CNT_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] sample_l,
  input  logic signed [SAMPLE_W-1:0] sample_r,
  input  logic [1:0]                 idx_code,
  input  logic [1:0]                 map_code,
  input  logic                       mute,
  output logic                       pwm_l_p,
  output logic                       pwm_l_n,
  output logic                       pwm_r_p,
  output logic                       pwm_r_n
);
  localparam int NCH = 2;

  map_cfg_t         cfg_next;
  logic [2:0]       eighths;
  logic             three_act;
  logic             fast_act;
  logic             mute_act;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign cfg_next = decode_map(map_code);
  assign eighths  = index_eighths(idx_code);

  always_ff @(posedge clk) begin
    if (rst) begin
      three_act <= 1'b0;
      fast_act  <= 1'b0;
      mute_act  <= 1'b1;
    end else if (wrap) begin
      three_act <= cfg_next.three_level;
      fast_act  <= cfg_next.fast;
      mute_act  <= mute;
    end
  end

  pwm_carrier #(
    .CNT_W(CNT_W)
  ) u_carrier (
    .clk (clk),
    .rst (rst),
    .fast(fast_act),
    .cnt (cnt),
    .wrap(wrap)
  );

  logic signed [SAMPLE_W-1:0] smp [NCH];
  logic pp [NCH];
  logic pn [NCH];

  assign smp[0] = sample_l;
  assign smp[1] = sample_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwm_chan #(
      .SAMPLE_W(SAMPLE_W),
      .CNT_W   (CNT_W)
    ) u_chan (
      .clk      (clk),
      .rst      (rst),
      .load     (wrap),
      .sample   (smp[ch]),
      .eighths  (eighths),
      .fast_next(cfg_next.fast),
      .mute_next(mute),
      .three_act(three_act),
      .mute_act (mute_act),
      .cnt      (cnt),
      .pwm_p    (pp[ch]),
      .pwm_n    (pn[ch])
    );
  end

  assign pwm_l_p = pp[0];
  assign pwm_l_n = pn[0];
  assign pwm_r_p = pp[1];
  assign pwm_r_n = pn[1];

endmodule

// File: tb/test_stereo_pwm_mod.sv
module test_stereo_pwm_mod;
  localparam int SW = 8;
  localparam int CW = 6;
  localparam int PF = 2 ** CW;
  localparam int PH = 2 ** (CW - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [SW-1:0] sample_l = '0;
  logic signed [SW-1:0] sample_r = '0;
  logic [1:0] idx_code = 2'b00;
  logic [1:0] map_code = 2'b00;
  logic mute = 1'b0;
  logic pwm_l_p, pwm_l_n, pwm_r_p, pwm_r_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  stereo_pwm_mod #(.SAMPLE_W(SW), .CNT_W(CW)) i_stereo_pwm_mod (
    .clk(clk), .rst(rst), .sample_l(sample_l), .sample_r(sample_r),
    .idx_code(idx_code), .map_code(map_code), .mute(mute),
    .pwm_l_p(pwm_l_p), .pwm_l_n(pwm_l_n), .pwm_r_p(pwm_r_p), .pwm_r_n(pwm_r_n)
  );

  always #5ns clk = ~clk;

  function automatic int exp_high(int x, int code, int per);
    return per / 2 + (((code + 4) * x * per) >>> (SW + 3));
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] mp, input logic [1:0] ix, input int xl, input int xr, input bit mt);
    @(negedge clk);
    map_code = mp; idx_code = ix; sample_l = SW'(xl); sample_r = SW'(xr); mute = mt;
    repeat (2) @(negedge clk);
  endtask

  // one whole period, from a rise of pwm_l_p to the next
  task automatic measure(output int per, output int hlp, output int hln, output int hrp,
                         output int hrn, output int diff_cyc, output int same_cyc, output bit n_at_start);
    bit prev;
    prev = pwm_l_p;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm_l_p && !prev) break;
      prev = pwm_l_p;
    end
    per = 0; hlp = 0; hln = 0; hrp = 0; hrn = 0; diff_cyc = 0; same_cyc = 0;
    n_at_start = pwm_l_n;
    for (int i = 0; i < 300; i++) begin
      hlp += int'(pwm_l_p); hln += int'(pwm_l_n);
      hrp += int'(pwm_r_p); hrn += int'(pwm_r_n);
      if (pwm_l_p != pwm_l_n || pwm_r_p != pwm_r_n) diff_cyc++;
      if (pwm_l_p == pwm_l_n || pwm_r_p == pwm_r_n) same_cyc++;
      per++;
      prev = pwm_l_p;
      @(negedge clk);
      if (pwm_l_p && !prev) break;
    end
  endtask

  task automatic check_period(input string req, input int per_exp, input int lp, input int ln,
                              input int rp, input int rn, input bit legs_equal);
    int per, hlp, hln, hrp, hrn, dc, sc;
    bit ns;
    measure(per, hlp, hln, hrp, hrn, dc, sc, ns);
    chk(per == per_exp, req, "period", per, per_exp);
    chk(hlp == lp, req, "left p high", hlp, lp);
    chk(hln == ln, req, "left n high", hln, ln);
    chk(hrp == rp, req, "right p high", hrp, rp);
    chk(hrn == rn, req, "right n high", hrn, rn);
    if (legs_equal) begin
      chk(dc == 0, req, "cycles with legs differing", dc, 0);
      chk(ns == 1'b1, req, "left n at period start", int'(ns), 1);
    end else begin
      chk(sc == 0, req, "cycles with legs equal", sc, 0);
      chk(ns == 1'b0, req, "left n at period start", int'(ns), 0);
    end
  endtask

  task automatic t_reset();
    int bad;
    bad = 0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    // R1 outputs low in reset
    chk({pwm_l_p, pwm_l_n, pwm_r_p, pwm_r_n} == 4'b0000, "R1", "outputs in reset",
        int'({pwm_l_p, pwm_l_n, pwm_r_p, pwm_r_n}), 0);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_l_p != pwm_l_n || pwm_r_p != pwm_r_n) bad++;
    end
    chk(bad == 0, "R1", "idle legs differ after reset", bad, 0);
  endtask

  task automatic t_ad_full();
    int xs_l [4] = '{0, 100, 127, -57};
    int xs_r [4] = '{0, -100, -128, 33};
    int ix   [4] = '{0, 1, 3, 2};
    for (int c = 0; c < 4; c++) begin
      int lp, rp;
      apply(2'b00, 2'(ix[c]), xs_l[c], xs_r[c], 1'b0);
      lp = exp_high(xs_l[c], ix[c], PF);
      rp = exp_high(xs_r[c], ix[c], PF);
      // R2 R3 R4 R5 R10
      check_period("R3/R4/R5/R10", PF, lp, PF - lp, rp, PF - rp, 1'b0);
    end
    // R11 extremes at the widest index still leave both edges
    apply(2'b00, 2'b11, 127, -128, 1'b0);
    begin
      int per, hlp, hln, hrp, hrn, dc, sc;
      bit ns;
      measure(per, hlp, hln, hrp, hrn, dc, sc, ns);
      chk(hlp > 0 && hlp < PF, "R11", "max sample high time", hlp, exp_high(127, 3, PF));
      chk(hrp > 0 && hrp < PF, "R11", "min sample high time", hrp, exp_high(-128, 3, PF));
    end
  endtask

  task automatic t_fast();
    int lp, rp;
    apply(2'b01, 2'b10, 90, -20, 1'b0);
    lp = exp_high(90, 2, PH);
    rp = exp_high(-20, 2, PH);
    // R2 R7 half period AD
    check_period("R2/R7", PH, lp, PH - lp, rp, PH - rp, 1'b0);
  endtask

  task automatic t_map11();
    int lp, rp;
    apply(2'b11, 2'b01, 64, -64, 1'b0);
    lp = exp_high(64, 1, PF);
    rp = exp_high(-64, 1, PF);
    // R7 code 11 behaves as full-period AD
    check_period("R7", PF, lp, PF - lp, rp, PF - rp, 1'b0);
  endtask

  task automatic t_bd();
    apply(2'b10, 2'b00, 0, 0, 1'b0);
    // R6 zero sample gives identical 50% legs
    check_period("R6", PF, PF / 2, PF / 2, PF / 2, PF / 2, 1'b1);
    apply(2'b10, 2'b11, 50, -90, 1'b0);
    begin
      int per, hlp, hln, hrp, hrn, dc, sc;
      bit ns;
      measure(per, hlp, hln, hrp, hrn, dc, sc, ns);
      chk(per == PF, "R7", "BD period", per, PF);
      chk(hlp == exp_high(50, 3, PF), "R6", "BD left p", hlp, exp_high(50, 3, PF));
      chk(hln == exp_high(-50, 3, PF), "R6", "BD left n", hln, exp_high(-50, 3, PF));
      chk(hrp == exp_high(-90, 3, PF), "R6", "BD right p", hrp, exp_high(-90, 3, PF));
      chk(hrn == exp_high(90, 3, PF), "R6", "BD right n", hrn, exp_high(90, 3, PF));
      chk(ns == 1'b1, "R6", "BD n high at period start", int'(ns), 1);
    end
  endtask

  task automatic t_mute();
    apply(2'b00, 2'b11, 100, -70, 1'b1);
    // R8 muted AD full period
    check_period("R8", PF, PF / 2, PF / 2, PF / 2, PF / 2, 1'b1);
    apply(2'b01, 2'b00, -128, 127, 1'b1);
    // R8 muted at half period
    check_period("R8", PH, PH / 2, PH / 2, PH / 2, PH / 2, 1'b1);
    apply(2'b10, 2'b10, 77, -33, 1'b1);
    check_period("R8", PF, PF / 2, PF / 2, PF / 2, PF / 2, 1'b1);
  endtask

  task automatic t_boundary();
    int cnt_h, lp, rp;
    bit prev;
    apply(2'b00, 2'b00, 40, 40, 1'b0);
    prev = pwm_l_p;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (pwm_l_p && !prev) break;
      prev = pwm_l_p;
    end
    cnt_h = 0;
    for (int i = 0; i < PF; i++) begin
      if (i > 0) @(negedge clk);
      if (i == 3) begin
        sample_l = -SW'(40); idx_code = 2'b11; map_code = 2'b01;
      end
      cnt_h += int'(pwm_l_p);
    end
    // R9 period in progress keeps old width
    chk(cnt_h == exp_high(40, 0, PF), "R9", "width during change", cnt_h, exp_high(40, 0, PF));
    lp = exp_high(-40, 3, PH);
    rp = exp_high(40, 3, PH);
    // R9 next period uses new sample, index and rate
    check_period("R9", PH, lp, PH - lp, rp, PH - rp, 1'b0);
  endtask

  initial begin
    t_reset();
    t_ad_full();
    t_fast();
    t_map11();
    t_bd();
    t_mute();
    t_boundary();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule